// File: doc/BRIEF.md
# Event-Paced Frame/Element DMA Channel

This block is one DMA channel that copies a block of data from a source address range to a destination address range with no processor involvement. The block is organised as a number of frames, and each frame holds a number of elements. An element is one data value: a byte, a half-word or a word. Each element is moved in two steps. First it is read from the source into a staging register. Then it is written from that register to the destination. The memory side is a single-beat request interface that uses a combinational acknowledge.

Software loads the whole channel setup in one cycle. That setup holds the start addresses, a signed element step, a signed frame step, the number of elements per frame (which is also the reload value), the frame count, the element size, the pacing mode, the trigger source and the priority. The channel then waits for trigger events, taken either from an on-chip peripheral line or from an external pin. Each event moves either one element or one whole frame, depending on the pacing mode. When the last element of the last frame has been written, the channel raises a completion flag and emits a one-cycle interrupt pulse.

Top module: `evdma_channel`

## Requirements
- R1: After reset, `mem_req`, `done` and `irq` are all low, and no memory request is issued until a configuration load followed by a trigger.
- R2: Each element is read at the current source address (`mem_we`=0) and then written at the current destination address (`mem_we`=1). The write data is the read data masked to the element size. `cfg_size` 0 selects byte (bits 31:8 cleared), 1 selects half-word (bits 31:16 cleared), and 2 or 3 selects word (no mask).
- R3: After an element that is not the last of its frame, both addresses advance by the signed element step. When `cfg_idx_auto` is 1, that step is the element size in bytes (1, 2 or 4) and `cfg_elem_idx` is ignored.
- R4: After the last element of a frame, the element count reloads to `cfg_elem_cnt`, the frame count decrements, and both addresses advance by the signed frame step instead of the element step.
- R5: With `cfg_frame_sync`=0, each accepted trigger moves exactly one element, and the channel then waits for the next trigger.
- R6: With `cfg_frame_sync`=1, each accepted trigger moves one whole frame, and the channel then waits for the next trigger.
- R7: `cfg_trig_sel`=0 takes triggers from `evt_periph` and `cfg_trig_sel`=1 takes them from `evt_pin`. The unselected line has no effect.
- R8: After the final element is written, `done` goes high and stays high until the next configuration load. `irq` pulses high for exactly one cycle at the same time, and no further requests are issued even if triggers arrive.
- R9: `mem_hi_prio` presents the priority bit captured at the last configuration load.
- R10: A trigger that arrives while the channel is busy is held, and it starts the next transfer unit once the current one ends.
- R11: A request that is not acknowledged holds its address, direction and write data stable until the acknowledge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load all configuration fields and arm the channel |
| cfg_src | input | 32 | Source start byte address |
| cfg_dst | input | 32 | Destination start byte address |
| cfg_elem_idx | input | 16 | Signed address step between elements |
| cfg_frame_idx | input | 16 | Signed address step at a frame boundary |
| cfg_elem_cnt | input | 16 | Elements per frame, also the reload value |
| cfg_frame_cnt | input | 16 | Number of frames in the block |
| cfg_size | input | 2 | Element size: 0 byte, 1 half-word, 2 or 3 word |
| cfg_idx_auto | input | 1 | Use the element size as the element step |
| cfg_frame_sync | input | 1 | 1: one frame per trigger, 0: one element per trigger |
| cfg_trig_sel | input | 1 | Trigger source: 0 peripheral, 1 pin |
| cfg_hi_prio | input | 1 | Priority of this channel over the processor |
| evt_periph | input | 1 | Peripheral trigger event |
| evt_pin | input | 1 | External pin trigger event |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Request byte address |
| mem_size | output | 2 | Access size, same encoding as `cfg_size` |
| mem_wdata | output | 32 | Write data |
| mem_hi_prio | output | 1 | Captured priority bit |
| mem_ack | input | 1 | Request accepted this cycle; read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Block complete |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The checker watches the memory handshake on every cycle. It holds that an unacknowledged request keeps its address, direction and data steady, that byte and half-word writes carry no bits above the element width, that the interrupt is a single pulse coinciding with the completion flag, and that no request follows completion. Address stepping by element and frame steps, the count reload at frame boundaries, the pacing of one element or one frame per event, trigger-source selection and the holding of an early trigger depend on the sequence of accesses. Only the bench scenarios can show these, by comparing every write against the address and data expected from the setup.

// File: rtl/evdma_pkg.sv
package evdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } ch_state_e;

  // Lane mask for a given element size code
  function automatic logic [31:0] lane_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    lane_mask = 32'h0000_00FF;
      2'd1:    lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  // Element size in bytes for a given size code
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/evdma_trig.sv
module evdma_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sel_pin,
  input  logic evt_periph,
  input  logic evt_pin,
  input  logic take,
  output logic fire
);
  logic pend_q, pend_d, trig_now;

  assign trig_now = sel_pin ? evt_pin : evt_periph;
  assign fire     = pend_q | trig_now;

  // One pending event is held; taking consumes the oldest
  always_comb begin
    if (clr)       pend_d = 1'b0;
    else if (take) pend_d = pend_q & trig_now;
    else           pend_d = pend_q | trig_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/evdma_addr.sv
module evdma_addr #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [IW-1:0] ld_eidx,
  input  logic [IW-1:0] ld_fidx,
  input  logic [CW-1:0] ld_ecnt,
  input  logic [CW-1:0] ld_fcnt,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic          last_elem,
  output logic          last_frame
);
  localparam int EXT = AW - IW;

  logic [AW-1:0] src_q, dst_q, src_d, dst_d, stride;
  logic [IW-1:0] eidx_q, fidx_q;
  logic [CW-1:0] reload_q, ecnt_q, fcnt_q, ecnt_d, fcnt_d;
  logic          upd;

  assign last_elem  = (ecnt_q <= CW'(1));
  assign last_frame = (fcnt_q <= CW'(1));
  assign src = src_q;
  assign dst = dst_q;
  assign upd = load | step;

  always_comb begin
    stride = last_elem ? {{EXT{fidx_q[IW-1]}}, fidx_q}
                       : {{EXT{eidx_q[IW-1]}}, eidx_q};
    if (load) begin
      src_d  = ld_src;
      dst_d  = ld_dst;
      ecnt_d = ld_ecnt;
      fcnt_d = ld_fcnt;
    end else begin
      src_d  = src_q + stride;
      dst_d  = dst_q + stride;
      ecnt_d = last_elem ? reload_q : ecnt_q - CW'(1);
      fcnt_d = last_elem ? fcnt_q - CW'(1) : fcnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      dst_q    <= '0;
      eidx_q   <= '0;
      fidx_q   <= '0;
      reload_q <= '0;
      ecnt_q   <= '0;
      fcnt_q   <= '0;
    end else begin
      if (upd) begin
        src_q  <= src_d;
        dst_q  <= dst_d;
        ecnt_q <= ecnt_d;
        fcnt_q <= fcnt_d;
      end
      if (load) begin
        eidx_q   <= ld_eidx;
        fidx_q   <= ld_fidx;
        reload_q <= ld_ecnt;
      end
    end
  end
endmodule

// File: rtl/evdma_ctrl.sv
module evdma_ctrl
  import evdma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic frame_sync,
  input  logic fire,
  input  logic ack,
  input  logic last_elem,
  input  logic last_frame,
  output logic take,
  output logic step,
  output logic cap,
  output logic req,
  output logic we,
  output logic done,
  output logic irq
);
  ch_state_e st_q, st_d;
  logic      sync_q, done_q, done_d, irq_q, irq_d;

  assign req  = (st_q == ST_RD) || (st_q == ST_WR);
  assign we   = (st_q == ST_WR);
  assign cap  = (st_q == ST_RD) && ack;
  assign done = done_q;
  assign irq  = irq_q;

  always_comb begin
    st_d   = st_q;
    done_d = done_q;
    irq_d  = 1'b0;
    take   = 1'b0;
    step   = 1'b0;
    if (load) begin
      st_d   = ST_WAIT;
      done_d = 1'b0;
    end else begin
      case (st_q)
        ST_WAIT: if (fire) begin
          take = 1'b1;
          st_d = ST_RD;
        end
        ST_RD: if (ack) st_d = ST_WR;
        ST_WR: if (ack) begin
          step = 1'b1;
          if (last_elem && last_frame) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            irq_d  = 1'b1;
          end else if (last_elem || !sync_q) begin
            st_d = ST_WAIT;
          end else begin
            st_d = ST_RD;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sync_q <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      irq_q  <= irq_d;
      if (load) sync_q <= frame_sync;
    end
  end
endmodule

// File: rtl/evdma_channel.sv
module evdma_channel
  import evdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [IW-1:0] cfg_elem_idx,
  input  logic [IW-1:0] cfg_frame_idx,
  input  logic [CW-1:0] cfg_elem_cnt,
  input  logic [CW-1:0] cfg_frame_cnt,
  input  logic [1:0]    cfg_size,
  input  logic          cfg_idx_auto,
  input  logic          cfg_frame_sync,
  input  logic          cfg_trig_sel,
  input  logic          cfg_hi_prio,
  input  logic          evt_periph,
  input  logic          evt_pin,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  output logic          mem_hi_prio,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          done,
  output logic          irq
);
  logic [IW-1:0] eidx_eff;
  logic [AW-1:0] src, dst;
  logic [31:0]   stage_q;
  logic [1:0]    size_q;
  logic          sel_q, prio_q;
  logic          fire, take, step, cap, last_elem, last_frame;

  assign eidx_eff = cfg_idx_auto ? IW'(size_bytes(cfg_size)) : cfg_elem_idx;

  evdma_trig u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cfg_we),
    .sel_pin    (sel_q),
    .evt_periph (evt_periph),
    .evt_pin    (evt_pin),
    .take       (take),
    .fire       (fire)
  );

  evdma_addr #(.AW(AW), .CW(CW), .IW(IW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cfg_we),
    .step       (step),
    .ld_src     (cfg_src),
    .ld_dst     (cfg_dst),
    .ld_eidx    (eidx_eff),
    .ld_fidx    (cfg_frame_idx),
    .ld_ecnt    (cfg_elem_cnt),
    .ld_fcnt    (cfg_frame_cnt),
    .src        (src),
    .dst        (dst),
    .last_elem  (last_elem),
    .last_frame (last_frame)
  );

  evdma_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cfg_we),
    .frame_sync (cfg_frame_sync),
    .fire       (fire),
    .ack        (mem_ack),
    .last_elem  (last_elem),
    .last_frame (last_frame),
    .take       (take),
    .step       (step),
    .cap        (cap),
    .req        (mem_req),
    .we         (mem_we),
    .done       (done),
    .irq        (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      size_q  <= '0;
      sel_q   <= 1'b0;
      prio_q  <= 1'b0;
    end else begin
      if (cap) stage_q <= mem_rdata & lane_mask(size_q);
      if (cfg_we) begin
        size_q <= cfg_size;
        sel_q  <= cfg_trig_sel;
        prio_q <= cfg_hi_prio;
      end
    end
  end

  assign mem_addr    = mem_we ? dst : src;
  assign mem_size    = size_q;
  assign mem_wdata   = stage_q;
  assign mem_hi_prio = prio_q;
endmodule

// File: rtl/evdma_chk.sv
module evdma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_size,
  input logic [31:0]   mem_wdata,
  input logic          done,
  input logic          irq
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !cfg_we) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_byte_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_size == 2'd0) |-> (mem_wdata[31:8] == 24'd0));

  assert_half_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_size == 2'd1) |-> (mem_wdata[31:16] == 16'd0));

  assert_irq_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
endmodule

bind evdma_channel evdma_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_size  (mem_size),
  .mem_wdata (mem_wdata),
  .done      (done),
  .irq       (irq)
);

// File: tb/evdma_channel_tb.sv
module evdma_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_src = '0, cfg_dst = '0;
  logic [15:0] cfg_elem_idx = '0, cfg_frame_idx = '0, cfg_elem_cnt = '0, cfg_frame_cnt = '0;
  logic [1:0]  cfg_size = '0;
  logic        cfg_idx_auto = 1'b0, cfg_frame_sync = 1'b0, cfg_trig_sel = 1'b0, cfg_hi_prio = 1'b0;
  logic        evt_periph = 1'b0, evt_pin = 1'b0;
  logic        mem_req, mem_we, mem_hi_prio, mem_ack, done, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        ack_gate = 1'b0;
  int          ack_cnt = 0;

  int n_checks = 0, n_err = 0, n_wr = 0, n_irq = 0;

  typedef struct packed { logic [31:0] addr; logic [31:0] data; } wr_item_t;
  wr_item_t exp_q[$];

  always #2 clk = ~clk;

  evdma_channel u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_elem_idx(cfg_elem_idx), .cfg_frame_idx(cfg_frame_idx),
    .cfg_elem_cnt(cfg_elem_cnt), .cfg_frame_cnt(cfg_frame_cnt), .cfg_size(cfg_size),
    .cfg_idx_auto(cfg_idx_auto), .cfg_frame_sync(cfg_frame_sync),
    .cfg_trig_sel(cfg_trig_sel), .cfg_hi_prio(cfg_hi_prio),
    .evt_periph(evt_periph), .evt_pin(evt_pin),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_hi_prio(mem_hi_prio), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .irq(irq)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'hA5C3, a[15:0] + 16'h1234};
  endfunction

  function automatic logic [31:0] msk(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // Memory model: acknowledge on two of every three cycles
  always @(posedge clk) begin
    ack_cnt  <= ack_cnt + 1;
    ack_gate <= ((ack_cnt % 3) != 0);
  end
  assign mem_ack   = mem_req & ack_gate;
  assign mem_rdata = pat(mem_addr);

  // Monitor: compare every write against the scoreboard
  always @(negedge clk) begin
    if (rst_n && irq) n_irq = n_irq + 1;
    if (rst_n && mem_req && mem_we && mem_ack) begin
      n_wr = n_wr + 1;
      n_checks = n_checks + 1;
      if (exp_q.size() == 0) begin
        n_err = n_err + 1;
        $display("FAIL R2 unexpected write addr=%h data=%h expected none", mem_addr, mem_wdata);
      end else begin
        wr_item_t e;
        e = exp_q.pop_front();
        if (mem_addr !== e.addr || mem_wdata !== e.data) begin
          n_err = n_err + 1;
          $display("FAIL R2 R3 R4 write addr=%h data=%h expected addr=%h data=%h",
                   mem_addr, mem_wdata, e.addr, e.data);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_err = n_err + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: load the setup and push the expected writes
  task automatic load_block(input logic [31:0] s, input logic [31:0] d,
                            input logic [15:0] eidx, input logic [15:0] fidx,
                            input int ecnt, input int fcnt, input logic [1:0] sz,
                            input bit auto_i, input bit fsync, input bit sel, input bit prio);
    logic [31:0] cs, cd, step_e;
    cs = s; cd = d;
    step_e = auto_i ? ((sz == 0) ? 32'd1 : (sz == 1) ? 32'd2 : 32'd4)
                    : {{16{eidx[15]}}, eidx};
    for (int f = 0; f < fcnt; f++) begin
      for (int e = 0; e < ecnt; e++) begin
        exp_q.push_back({cd, pat(cs) & msk(sz)});
        if (e == ecnt - 1) begin
          cs = cs + {{16{fidx[15]}}, fidx};
          cd = cd + {{16{fidx[15]}}, fidx};
        end else begin
          cs = cs + step_e;
          cd = cd + step_e;
        end
      end
    end
    @(negedge clk);
    cfg_src = s; cfg_dst = d; cfg_elem_idx = eidx; cfg_frame_idx = fidx;
    cfg_elem_cnt = 16'(ecnt); cfg_frame_cnt = 16'(fcnt); cfg_size = sz;
    cfg_idx_auto = auto_i; cfg_frame_sync = fsync; cfg_trig_sel = sel; cfg_hi_prio = prio;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input bit pin, input int len);
    @(negedge clk);
    if (pin) evt_pin = 1'b1; else evt_periph = 1'b1;
    repeat (len) @(negedge clk);
    evt_pin = 1'b0; evt_periph = 1'b0;
  endtask

  task automatic wait_wr(input int target, input string req);
    for (int i = 0; i < 500 && n_wr < target; i++) @(negedge clk);
    check(n_wr == target, req, n_wr, target);
  endtask

  task automatic idle_check(input int target, input string req);
    repeat (12) @(negedge clk);
    check(n_wr == target, req, n_wr, target);
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks = n_checks + 1;
    n_err = n_err + 1;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int base, irq0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    check(!mem_req && !done && !irq, "R1 reset outputs", int'({mem_req, done, irq}), 0);
    pulse(1'b0, 1);
    idle_check(0, "R1 no request before load");

    // Block A: word elements, auto step, one frame per peripheral trigger
    irq0 = n_irq;
    load_block(32'h1000, 32'h8000, 16'h0, 16'h0040, 4, 3, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1);
    check(mem_hi_prio == 1'b1, "R9 priority high", int'(mem_hi_prio), 1);
    for (int f = 1; f <= 3; f++) begin
      pulse(1'b0, 1);
      wait_wr(4 * f, "R6 frame per trigger");
      if (f < 3) idle_check(4 * f, "R6 waits after frame");
    end
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R8 done after block A", int'(done), 1);
    check(n_irq - irq0 == 1, "R8 single irq pulse", n_irq - irq0, 1);

    // Block B: bytes, explicit step 3, negative frame step, per-element, pin trigger
    base = n_wr; irq0 = n_irq;
    load_block(32'h2000, 32'h9001, 16'h0003, 16'hFFF8, 2, 2, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    check(done == 1'b0, "R8 load clears done", int'(done), 0);
    check(mem_hi_prio == 1'b0, "R9 priority low", int'(mem_hi_prio), 0);
    pulse(1'b0, 1);
    idle_check(base, "R7 unselected line ignored");
    pulse(1'b1, 1);
    wait_wr(base + 1, "R5 one element per trigger");
    idle_check(base + 1, "R5 waits after element");
    pulse(1'b1, 2);  // two events: second arrives while busy
    wait_wr(base + 3, "R10 held trigger served");
    pulse(1'b1, 1);
    wait_wr(base + 4, "R5 last element");
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R8 done after block B", int'(done), 1);
    check(n_irq - irq0 == 1, "R8 irq once in block B", n_irq - irq0, 1);

    // Block C: half-words, one element per frame, reload at every boundary
    base = n_wr; irq0 = n_irq;
    load_block(32'h3002, 32'hA000, 16'h0, 16'h0010, 1, 2, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0);
    pulse(1'b1, 1);
    wait_wr(base + 1, "R4 frame of one element");
    idle_check(base + 1, "R6 wait for second frame");
    pulse(1'b1, 1);
    wait_wr(base + 2, "R4 reload and frame step");
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R8 done after block C", int'(done), 1);
    pulse(1'b1, 1);
    idle_check(base + 2, "R8 triggers ignored after done");
    check(mem_req == 1'b0, "R8 no request after done", int'(mem_req), 0);
    check(n_irq - irq0 == 1, "R8 irq once in block C", n_irq - irq0, 1);
    check(exp_q.size() == 0, "R2 all expected writes seen", exp_q.size(), 0);
    report();
  end
endmodule